// File: doc/BRIEF.md
# Streaming Line Dilation and Erosion Filter

This block filters a raster pixel stream one row at a time. Each output pixel is the maximum (dilation) or the minimum (erosion) of the input pixels that a flat horizontal segment covers. The segment has a programmable length and a programmable anchor, the origin, which says which member of the segment sits over the output pixel. Pixel `j` of a row of width `W` is filtered over input columns `j - org` to `j - org + len - 1`. Columns that fall outside `0 .. W-1` do not exist and take no part in the result.

The block keeps a short queue of candidate pixels whose values run monotonically from head to tail. Each input pixel is compared against the queue in a single cycle. At most one stale entry leaves the head for each output pixel. The work per pixel is therefore one cycle, whatever the segment length. Each queue entry holds only the low bits of its column index, enough to tell the one stale candidate apart from the live window.

Both data sides use valid/ready handshakes. A transfer takes place on a rising clock edge where valid and ready are both high. The output holds its value and its valid while `out_ready` is low. The input is stalled, with `in_ready` low, whenever accepting another pixel would move beyond the window of the next pending output. While the input is stalled, a pending output that is accepted in a cycle frees room for an input pixel in that same cycle, so `in_ready` may depend on `out_ready` through logic. A row begins with a pixel flagged by `in_sol`. The operation, segment length, origin and row width are captured from the control pins with that pixel. After the last output of the row the block returns to idle, and idle lasts at least one cycle.

Top module: `line_morph_filter`

## Requirements
- R1: With `op_erode` = 0 (dilation), output pixel `j` equals the maximum of the input pixels at columns max(0, j-org) to min(W-1, j-org+len-1) of the same row.
- R2: With `op_erode` = 1 (erosion), output pixel `j` equals the minimum over the same clipped column range. Equal values are handled so that the result is still exact.
- R3: Each row produces exactly W output pixels, in column order. No output appears between rows.
- R4: The window is clipped at both row edges, including rows shorter than the segment and rows of width 1.
- R5: A segment length of 0 is used as 1 and a length above MAX_SEG is used as MAX_SEG. An origin at or beyond the effective length is used as length-1. A row width of 0 is used as 1 and a width above MAX_WIDTH is used as MAX_WIDTH.
- R6: The operation, length, origin and width are sampled only with the start-of-row pixel. Changes on those pins during a row do not affect that row's outputs.
- R7: While idle, a pixel with `in_sol` = 0 is accepted and discarded, with no output and no effect on the next row. While a row is active, `in_sol` is ignored.
- R8: While idle, `in_ready` is high and `out_valid` is low; this is also the state after reset. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pix` stays unchanged.
- R9: With input always valid and output always ready, a row of W pixels completes within W + len + 3 cycles, counted from the cycle its first pixel is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_erode | input | 1 | 0 = running maximum, 1 = running minimum; sampled at row start |
| seg_len | input | $clog2(MAX_SEG+1) | Segment length in pixels; sampled at row start |
| seg_org | input | $clog2(MAX_SEG+1) | Origin offset inside the segment; sampled at row start |
| line_width | input | $clog2(MAX_WIDTH+1) | Row width in pixels; sampled at row start |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take an input pixel |
| in_sol | input | 1 | Marks the first pixel of a row |
| in_pix | input | PIX_W | Input pixel value |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take the output pixel |
| out_pix | output | PIX_W | Filtered pixel value |

## Verification
The bench aims at the queue's eviction rules. Rising and falling ramps, runs of equal values and random data are each filtered as both maximum and minimum. A wrong dominance test, or a wrong treatment of ties, leaves a value in the queue that no longer belongs there, or drops one that does, and the result is off. Origins at zero and at the segment end, segments longer than the row, and a one-pixel row test the clipping and the stale-head detection. A design that got these wrong would leak a pixel from outside the window into the result, or produce the wrong number of outputs. Random gaps on the input and random back-pressure on the output check that a held output never changes. They also check that the input stall never lets a pixel into the queue ahead of the window it belongs to. Further tests change the control pins during a row and send stray pixels without `in_sol`. A design that sampled the controls continuously, or honoured `in_sol` at the wrong time, would corrupt the row.

// File: rtl/line_morph_pkg.sv
package line_morph_pkg;

  typedef enum logic {
    OP_DILATE = 1'b0,
    OP_ERODE  = 1'b1
  } morph_op_e;

  // A held candidate survives a newcomer only if it is strictly better.
  // Pixel widths up to 16 bits are supported by this helper.
  function automatic logic survives(morph_op_e op, logic [15:0] held,
                                    logic [15:0] incoming);
    if (op == OP_ERODE) return held < incoming;
    return held > incoming;
  endfunction

endpackage

// File: rtl/line_morph_ctrl.sv
module line_morph_ctrl
  import line_morph_pkg::*;
#(
  parameter int MAX_SEG   = 31,
  parameter int MAX_WIDTH = 1024
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 op_sel,
  input  logic [$clog2(MAX_SEG+1)-1:0]         seg_len,
  input  logic [$clog2(MAX_SEG+1)-1:0]         seg_org,
  input  logic [$clog2(MAX_WIDTH+1)-1:0]       line_width,
  input  logic                                 in_valid,
  input  logic                                 in_sol,
  input  logic                                 out_ready,
  output logic                                 in_ready,
  output logic                                 out_valid,
  output logic                                 push,
  output logic                                 out_fire,
  output logic                                 line_end,
  output logic                                 busy,
  output morph_op_e                            op_q,
  output logic [$clog2(MAX_SEG+1)-1:0]         len_q,
  output logic [$clog2(MAX_SEG+1)-1:0]         org_q,
  output logic [$clog2(MAX_WIDTH+1)-1:0]       wid_q,
  output logic [$clog2(MAX_WIDTH+1)-1:0]       in_cnt,
  output logic [$clog2(MAX_WIDTH+1)-1:0]       out_cnt
);

  localparam int LW = $clog2(MAX_SEG + 1);
  localparam int CW = $clog2(MAX_WIDTH + 1);

  logic [LW-1:0] len_c, org_c, thr;
  logic [CW-1:0] wid_c, lead;
  logic          line_full, in_fire, start;

  // Clamp the control pins into the legal range before capture.
  always_comb begin
    if (seg_len == '0)                 len_c = LW'(1);
    else if (32'(seg_len) > MAX_SEG)   len_c = LW'(MAX_SEG);
    else                               len_c = seg_len;
    org_c = (seg_org >= len_c) ? len_c - LW'(1) : seg_org;
    if (line_width == '0)                 wid_c = CW'(1);
    else if (32'(line_width) > MAX_WIDTH) wid_c = CW'(MAX_WIDTH);
    else                                  wid_c = line_width;
  end

  // thr: how far the input may run ahead of the oldest pending output.
  assign thr       = len_q - org_q;
  assign lead      = in_cnt - out_cnt;
  assign line_full = (in_cnt == wid_q);
  assign out_valid = busy && (line_full || (32'(lead) == 32'(thr)));
  assign out_fire  = out_valid && out_ready;
  assign in_ready  = !busy || (!line_full && ((32'(lead) < 32'(thr)) || out_fire));
  assign in_fire   = in_valid && in_ready;
  assign start     = in_fire && !busy && in_sol;
  assign push      = in_fire && (busy || in_sol);
  assign line_end  = out_fire && (out_cnt == wid_q - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      in_cnt  <= '0;
      out_cnt <= '0;
      op_q    <= OP_DILATE;
      len_q   <= LW'(1);
      org_q   <= '0;
      wid_q   <= CW'(1);
    end else if (start) begin
      busy    <= 1'b1;
      in_cnt  <= CW'(1);
      out_cnt <= '0;
      op_q    <= morph_op_e'(op_sel);
      len_q   <= len_c;
      org_q   <= org_c;
      wid_q   <= wid_c;
    end else if (busy) begin
      if (line_end) begin
        busy    <= 1'b0;
        in_cnt  <= '0;
        out_cnt <= '0;
      end else begin
        in_cnt  <= in_cnt + CW'(in_fire);
        out_cnt <= out_cnt + CW'(out_fire);
      end
    end
  end

endmodule

// File: rtl/line_morph_queue.sv
module line_morph_queue
  import line_morph_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int DEPTH = 32,
  parameter int PB    = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  morph_op_e                     op,
  input  logic                          push,
  input  logic                          pop_req,
  input  logic                          flush,
  input  logic [PIX_W-1:0]              din,
  input  logic [PB-1:0]                 din_pos,
  input  logic [PB-1:0]                 stale_pos,
  output logic [PIX_W-1:0]              head_pix,
  output logic [$clog2(DEPTH+1)-1:0]    fill
);

  localparam int QCW = $clog2(DEPTH + 1);

  logic [PIX_W-1:0] val_q   [DEPTH];
  logic [PB-1:0]    pos_q   [DEPTH];
  logic [PIX_W-1:0] src_val [DEPTH];
  logic [PB-1:0]    src_pos [DEPTH];
  logic [DEPTH-1:0] keep;
  logic [QCW-1:0]   cnt_q, src_cnt, ins;
  logic             stale, pop;

  // Only the head can be stale, and only by exactly one column.
  assign stale    = (cnt_q != '0) && (pos_q[0] == stale_pos);
  assign head_pix = stale ? val_q[1] : val_q[0];
  assign pop      = pop_req && stale;
  assign src_cnt  = cnt_q - QCW'(pop);
  assign fill     = cnt_q;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      if (g + 1 < DEPTH) begin : g_shift
        assign src_val[g] = pop ? val_q[g+1] : val_q[g];
        assign src_pos[g] = pop ? pos_q[g+1] : pos_q[g];
      end else begin : g_last
        assign src_val[g] = val_q[g];
        assign src_pos[g] = pos_q[g];
      end

      assign keep[g] = (QCW'(g) < src_cnt) &&
                       survives(op, 16'(src_val[g]), 16'(din));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q[g] <= '0;
          pos_q[g] <= '0;
        end else if (push && (QCW'(g) == ins)) begin
          val_q[g] <= din;
          pos_q[g] <= din_pos;
        end else begin
          val_q[g] <= src_val[g];
          pos_q[g] <= src_pos[g];
        end
      end
    end
  endgenerate

  // Survivors form a prefix; the newcomer lands right after it.
  always_comb begin
    ins = '0;
    for (int k = 0; k < DEPTH; k++) ins = ins + QCW'(keep[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (flush) cnt_q <= '0;
    else if (push)  cnt_q <= ins + QCW'(1);
    else            cnt_q <= src_cnt;
  end

endmodule

// File: rtl/line_morph_filter.sv
module line_morph_filter
  import line_morph_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int MAX_SEG   = 31,
  parameter int MAX_WIDTH = 1024
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               op_erode,
  input  logic [$clog2(MAX_SEG+1)-1:0]       seg_len,
  input  logic [$clog2(MAX_SEG+1)-1:0]       seg_org,
  input  logic [$clog2(MAX_WIDTH+1)-1:0]     line_width,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic                               in_sol,
  input  logic [PIX_W-1:0]                   in_pix,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [PIX_W-1:0]                   out_pix
);

  localparam int LW    = $clog2(MAX_SEG + 1);
  localparam int CW    = $clog2(MAX_WIDTH + 1);
  localparam int DEPTH = MAX_SEG + 1;
  localparam int PB    = $clog2(MAX_SEG + 1);
  localparam int QCW   = $clog2(DEPTH + 1);

  logic          push, out_fire, line_end, busy;
  morph_op_e     op_q;
  logic [LW-1:0] len_q, org_q;
  logic [CW-1:0] wid_q, in_cnt, out_cnt;
  logic [PB-1:0] din_pos, stale_pos;
  logic [QCW-1:0] q_fill;

  line_morph_ctrl #(.MAX_SEG(MAX_SEG), .MAX_WIDTH(MAX_WIDTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .op_sel(op_erode), .seg_len(seg_len),
    .seg_org(seg_org), .line_width(line_width), .in_valid(in_valid),
    .in_sol(in_sol), .out_ready(out_ready), .in_ready(in_ready),
    .out_valid(out_valid), .push(push), .out_fire(out_fire),
    .line_end(line_end), .busy(busy), .op_q(op_q), .len_q(len_q),
    .org_q(org_q), .wid_q(wid_q), .in_cnt(in_cnt), .out_cnt(out_cnt)
  );

  // Column indices kept modulo 2^PB; the window never spans more.
  assign din_pos   = PB'(in_cnt);
  assign stale_pos = PB'(out_cnt) - PB'(org_q) - PB'(1);

  line_morph_queue #(.PIX_W(PIX_W), .DEPTH(DEPTH), .PB(PB)) queue_i (
    .clk(clk), .rst_n(rst_n), .op(op_q), .push(push), .pop_req(out_fire),
    .flush(line_end), .din(in_pix), .din_pos(din_pos),
    .stale_pos(stale_pos), .head_pix(out_pix), .fill(q_fill)
  );

endmodule

// File: rtl/line_morph_chk.sv
module line_morph_chk #(
  parameter int PIX_W = 8,
  parameter int LW    = 5,
  parameter int CW    = 11,
  parameter int QCW   = 6,
  parameter int DEPTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pix,
  input logic             busy,
  input logic [LW-1:0]    len_q,
  input logic [LW-1:0]    org_q,
  input logic [CW-1:0]    in_cnt,
  input logic [CW-1:0]    out_cnt,
  input logic [QCW-1:0]   q_fill
);

  a_r8_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  a_r8_idle_state: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (in_ready && !out_valid));

  a_r3_out_behind_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cnt < in_cnt));

  a_r1_window_lead: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(in_cnt - out_cnt) <= 32'(len_q) - 32'(org_q)));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    32'(q_fill) <= DEPTH);

endmodule

bind line_morph_filter line_morph_chk #(
  .PIX_W(PIX_W), .LW(LW), .CW(CW), .QCW(QCW), .DEPTH(DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_pix(out_pix), .busy(busy), .len_q(len_q),
  .org_q(org_q), .in_cnt(in_cnt), .out_cnt(out_cnt), .q_fill(q_fill)
);

// File: tb/line_morph_filter_tb.sv
module line_morph_filter_tb_top;

  localparam int PIX_W = 8, MAX_SEG = 31, MAX_WIDTH = 1024;
  localparam int LW = $clog2(MAX_SEG + 1), CW = $clog2(MAX_WIDTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_erode = 1'b0, in_valid = 1'b0, in_sol = 1'b0, out_ready = 1'b0;
  logic [LW-1:0] seg_len = '0, seg_org = '0;
  logic [CW-1:0] line_width = '0;
  logic [PIX_W-1:0] in_pix = '0;
  logic in_ready, out_valid;
  logic [PIX_W-1:0] out_pix;

  int n_checks = 0, n_fail = 0;
  int arr [64];
  logic [7:0] lfsr = 8'hA5;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  line_morph_filter #(.PIX_W(PIX_W), .MAX_SEG(MAX_SEG), .MAX_WIDTH(MAX_WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_erode(op_erode), .seg_len(seg_len),
    .seg_org(seg_org), .line_width(line_width), .in_valid(in_valid),
    .in_ready(in_ready), .in_sol(in_sol), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  task automatic check(string req, int act, int exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void fill(int pat, int seed, int w);
    for (int k = 0; k < 64; k++) begin
      case (pat)
        0: arr[k] = (k * 73 + seed * 29 + k * k * 11) & 255;
        1: arr[k] = (k * 5 + seed) & 255;
        2: arr[k] = (250 - k * 5) & 255;
        default: arr[k] = ((k / 3) * 37 + seed) & 255;
      endcase
    end
    if (w < 0) arr[0] = 0;
  endfunction

  function automatic int ref_pix(int j, int w, int len, int org, bit ero);
    int lo = j - org, hi = j - org + len - 1, r;
    if (lo < 0) lo = 0;
    if (hi > w - 1) hi = w - 1;
    r = arr[lo];
    for (int c = lo; c <= hi; c++)
      if (ero ? (arr[c] < r) : (arr[c] > r)) r = arr[c];
    return r;
  endfunction

  // One row: pattern, config, optional back-pressure, mid-row config
  // change, mid-row in_sol, optional throughput bound.
  task automatic run_line(string req, int w, int len, int org, bit ero,
                          int pat, int seed, bit bp, bit chg, bit msol,
                          int max_cyc);
    int elen, eorg, idx = 0, oidx = 0, cyc = 0;
    fill(pat, seed, w);
    elen = (len == 0) ? 1 : ((len > MAX_SEG) ? MAX_SEG : len);
    eorg = (org >= elen) ? elen - 1 : org;
    while (oidx < w && cyc < 3000) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      in_valid = (idx < w) && (!bp || lfsr[5] || lfsr[1]);
      in_pix   = PIX_W'(arr[(idx < 64) ? idx : 63]);
      in_sol   = (idx == 0) || (msol && idx == 3);
      if (chg && idx >= 1) begin
        op_erode = !ero; seg_len = LW'(3); seg_org = '0; line_width = CW'(w + 5);
      end else begin
        op_erode = ero; seg_len = LW'(len); seg_org = LW'(org); line_width = CW'(w);
      end
      out_ready = !bp || lfsr[0] || lfsr[3];
      #1;
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready) begin
        check(req, int'(out_pix), ref_pix(oidx, w, elen, eorg, ero),
              $sformatf("pixel %0d", oidx));
        oidx++;
      end
      cyc++;
    end
    check(req, oidx, w, "R3 output count");
    if (max_cyc > 0) check("R9", (cyc <= max_cyc) ? 1 : 0, 1, "row cycle bound");
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1; in_sol = 1'b0;
    #1;
    check("R3", int'(out_valid), 0, "no output after row");
    check("R8", int'(in_ready), 1, "idle ready after row");
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R8", int'(out_valid), 0, "reset out_valid");
    check("R8", int'(in_ready), 1, "reset in_ready");
  endtask

  task automatic t_stray_pixel();
    @(negedge clk);
    in_valid = 1'b1; in_sol = 1'b0; in_pix = 8'd255; out_ready = 1'b1;
    #1;
    check("R7", int'(in_ready), 1, "stray pixel accepted");
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R7", int'(out_valid), 0, "no output from stray pixel");
      @(negedge clk);
    end
    // Small ramp: a leaked 255 would show up in the maximum.
    run_line("R7", 10, 4, 1, 1'b0, 1, 3, 1'b0, 1'b0, 1'b1, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    run_line("R1", 16, 5, 2, 1'b0, 0, 1, 1'b0, 1'b0, 1'b0, 16 + 5 + 3);
    run_line("R2", 20, 7, 0, 1'b1, 0, 2, 1'b1, 1'b0, 1'b0, 0);
    run_line("R2", 18, 6, 2, 1'b1, 3, 5, 1'b1, 1'b0, 1'b0, 0);
    run_line("R1", 18, 6, 3, 1'b0, 3, 9, 1'b1, 1'b0, 1'b0, 0);
    run_line("R1", 24, 9, 4, 1'b0, 1, 0, 1'b1, 1'b0, 1'b0, 0);
    run_line("R2", 24, 9, 4, 1'b1, 2, 0, 1'b1, 1'b0, 1'b0, 0);
    run_line("R5", 12, 4, 3, 1'b0, 0, 4, 1'b1, 1'b0, 1'b0, 0);
    run_line("R5", 8, 1, 0, 1'b1, 0, 6, 1'b0, 1'b0, 1'b0, 0);
    run_line("R5", 10, 0, 5, 1'b0, 0, 7, 1'b0, 1'b0, 1'b0, 0);
    run_line("R5", 14, 4, 9, 1'b1, 0, 8, 1'b1, 1'b0, 1'b0, 0);
    run_line("R4", 40, 31, 15, 1'b0, 0, 11, 1'b1, 1'b0, 1'b0, 0);
    run_line("R4", 6, 31, 30, 1'b1, 0, 12, 1'b0, 1'b0, 1'b0, 0);
    run_line("R4", 1, 5, 2, 1'b0, 0, 13, 1'b0, 1'b0, 1'b0, 0);
    run_line("R6", 20, 7, 5, 1'b0, 0, 14, 1'b1, 1'b1, 1'b0, 0);
    run_line("R1", 48, 13, 6, 1'b0, 0, 15, 1'b0, 1'b0, 1'b0, 48 + 13 + 3);
    t_stray_pixel();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule